// File: doc/BRIEF.md
# Reservation Monitor for Linked Load / Conditional Store

This block holds a small word-addressed data store and serves several requesters at once, one request lane per requester. It provides atomic read-modify-write through a paired operation. A linked load returns a word and places a reservation on that word for the issuing requester. A conditional store writes only if the reservation is still intact. It returns 1 when it commits and 0 when it does not, in place of the data that a load would return.

Every lane may present one request per cycle. Within a cycle the lanes are serialised by index, with lane 0 first. Each lane sees the store contents and the reservations exactly as the lower-indexed lanes left them. Responses and write strobes appear one cycle after the request. Each requester owns one reservation, made of a valid flag and a word address. Any committed write to that address removes the reservation. The lane index serves as the requester identity. DEPTH must be a power of two so that every address value is in range.

Top module: `llsc_monitor`

## Requirements
- R1: After reset every reservation is invalid, every stored word is zero, and rsp_valid, mem_we and rsp_data are all zero.
- R2: The request codes are 0 idle, 1 load, 2 store, 3 linked load and 4 conditional store. A load or linked load returns the addressed word on rsp_data with rsp_valid high one cycle later, and mem_we stays low.
- R3: A linked load records a reservation on its address for its lane. A conditional store from the same lane to that address, with no committed write to it in between, writes its data, raises mem_we and returns 1.
- R4: A conditional store whose lane holds no valid reservation, or whose address differs from the reserved one, returns 0, keeps mem_we low and leaves the stored data unchanged.
- R5: A conditional store always clears its own lane's reservation, whether it succeeds or fails.
- R6: A plain store from any lane to a reserved address clears that reservation. A store to a different address leaves the reservation intact.
- R7: A successful conditional store from another lane to the reserved address clears the reservation. A failed one does not.
- R8: Requests in the same cycle take effect in lane order, lowest index first. A write from a lower lane invalidates a reservation that a higher lane then tests in the same cycle, and a read on a higher lane returns data written by a lower lane in that cycle.
- R9: When two lanes write the same address in one cycle, the higher-indexed lane's data remains.
- R10: A plain store always writes. It raises mem_we, with rsp_valid high and rsp_data zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_op | input | NREQ x 3 | Request code per lane |
| req_addr | input | NREQ x AW | Word address per lane |
| req_wdata | input | NREQ x W | Store data per lane |
| rsp_valid | output | NREQ | Response present for the previous cycle's request |
| rsp_data | output | NREQ x W | Loaded word, or conditional-store status 1/0 |
| mem_we | output | NREQ | The lane's write committed to the store |

## Verification
Lane-ordering collisions matter most here. A plain store on lane 0 and a conditional store on lane 1 to the same reserved word are issued in the same cycle, and lane 1 must fail. Two conditional stores that both hold a reservation are issued together, and only lane 0 may commit. Same-cycle writes to one address are judged by a later load, which must return lane 1's data. A store on lane 0 paired with a load on lane 1 shows whether the read sees the lower lane's write.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_LINK  = 3'd3,
        OP_COND  = 3'd4
    } llsc_op_e;
endpackage

// File: rtl/llsc_resv_match.sv
// Produces the mask of reservations that a committed write to wr_addr removes.
module llsc_resv_match #(
    parameter int NREQ = 2,
    parameter int AW   = 4
) (
    input  logic                     wr_hit,
    input  logic [AW-1:0]            wr_addr,
    input  logic [NREQ-1:0]          rv,
    input  logic [NREQ-1:0][AW-1:0]  ra,
    output logic [NREQ-1:0]          clr
);
    for (genvar j = 0; j < NREQ; j++) begin : g_cmp
        assign clr[j] = wr_hit && rv[j] && (ra[j] == wr_addr);
    end
endmodule

// File: rtl/llsc_lane_step.sv
// Applies one lane's request to the state left by the lower-indexed lanes.
module llsc_lane_step
    import llsc_pkg::*;
#(
    parameter int NREQ  = 2,
    parameter int W     = 32,
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int LANE  = 0
) (
    input  logic [2:0]                  op,
    input  logic [AW-1:0]               addr,
    input  logic [W-1:0]                wdata,
    input  logic [DEPTH-1:0][W-1:0]     mem_i,
    input  logic [NREQ-1:0]             rv_i,
    input  logic [NREQ-1:0][AW-1:0]     ra_i,
    output logic [DEPTH-1:0][W-1:0]     mem_o,
    output logic [NREQ-1:0]             rv_o,
    output logic [NREQ-1:0][AW-1:0]     ra_o,
    output logic                        vld_o,
    output logic [W-1:0]                rsp_o,
    output logic                        we_o
);
    logic            own_ok;
    logic            wr_hit;
    logic [NREQ-1:0] clr;

    assign own_ok = rv_i[LANE] && (ra_i[LANE] == addr);
    assign wr_hit = (op == OP_STORE) || ((op == OP_COND) && own_ok);

    llsc_resv_match #(.NREQ(NREQ), .AW(AW)) u_match (
        .wr_hit (wr_hit),
        .wr_addr(addr),
        .rv     (rv_i),
        .ra     (ra_i),
        .clr    (clr)
    );

    always_comb begin
        mem_o = mem_i;
        rv_o  = rv_i & ~clr;
        ra_o  = ra_i;
        vld_o = (op != OP_IDLE);
        rsp_o = '0;
        we_o  = wr_hit;
        if (wr_hit) begin
            mem_o[addr] = wdata;
        end
        case (op)
            OP_LOAD: rsp_o = mem_i[addr];
            OP_LINK: begin
                rsp_o      = mem_i[addr];
                rv_o[LANE] = 1'b1;
                ra_o[LANE] = addr;
            end
            OP_COND: begin
                rsp_o      = {{(W-1){1'b0}}, own_ok};
                rv_o[LANE] = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NREQ  = 2,
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NREQ-1:0][2:0]     req_op,
    input  logic [NREQ-1:0][AW-1:0]  req_addr,
    input  logic [NREQ-1:0][W-1:0]   req_wdata,
    output logic [NREQ-1:0]          rsp_valid,
    output logic [NREQ-1:0][W-1:0]   rsp_data,
    output logic [NREQ-1:0]          mem_we
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0]   mem;
        logic [NREQ-1:0]           rv;
        logic [NREQ-1:0][AW-1:0]   ra;
        logic [NREQ-1:0]           vld;
        logic [NREQ-1:0][W-1:0]    rsp;
        logic [NREQ-1:0]           we;
    } state_t;

    state_t st_d, st_q;

    logic [NREQ:0][DEPTH-1:0][W-1:0] mem_ch;
    logic [NREQ:0][NREQ-1:0]         rv_ch;
    logic [NREQ:0][NREQ-1:0][AW-1:0] ra_ch;
    logic [NREQ-1:0]                 vld_l;
    logic [NREQ-1:0][W-1:0]          rsp_l;
    logic [NREQ-1:0]                 we_l;

    assign mem_ch[0] = st_q.mem;
    assign rv_ch[0]  = st_q.rv;
    assign ra_ch[0]  = st_q.ra;

    for (genvar g = 0; g < NREQ; g++) begin : g_lane
        llsc_lane_step #(
            .NREQ(NREQ), .W(W), .DEPTH(DEPTH), .AW(AW), .LANE(g)
        ) u_step (
            .op    (req_op[g]),
            .addr  (req_addr[g]),
            .wdata (req_wdata[g]),
            .mem_i (mem_ch[g]),
            .rv_i  (rv_ch[g]),
            .ra_i  (ra_ch[g]),
            .mem_o (mem_ch[g+1]),
            .rv_o  (rv_ch[g+1]),
            .ra_o  (ra_ch[g+1]),
            .vld_o (vld_l[g]),
            .rsp_o (rsp_l[g]),
            .we_o  (we_l[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.mem = mem_ch[NREQ];
        st_d.rv  = rv_ch[NREQ];
        st_d.ra  = ra_ch[NREQ];
        st_d.vld = vld_l;
        st_d.rsp = rsp_l;
        st_d.we  = we_l;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.vld;
    assign rsp_data  = st_q.rsp;
    assign mem_we    = st_q.we;

    for (genvar g = 0; g < NREQ; g++) begin : g_chk
        AST_COND_CLEARS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
            (req_op[g] == OP_COND) |=> !st_q.rv[g]); // R5
        AST_COND_UNRESERVED_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
            (req_op[g] == OP_COND && !(st_q.rv[g] && st_q.ra[g] == req_addr[g]))
            |=> (!mem_we[g] && rsp_data[g] == '0)); // R4
        AST_COND_STATUS_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (req_op[g] == OP_COND) |=> (rsp_data[g] == {{(W-1){1'b0}}, mem_we[g]})); // R3
        AST_READ_NEVER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
            (req_op[g] == OP_LOAD || req_op[g] == OP_LINK || req_op[g] == OP_IDLE)
            |=> !mem_we[g]); // R2
        AST_STORE_ALWAYS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && req_op[g] == OP_STORE) |=> (mem_we[g] && rsp_valid[g])); // R10
        AST_RESP_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && req_op[g] != OP_IDLE) |=> rsp_valid[g]); // R2
    end

    AST_LAST_LINK_RESERVES: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && req_op[NREQ-1] == OP_LINK)
        |=> (st_q.rv[NREQ-1] && st_q.ra[NREQ-1] == $past(req_addr[NREQ-1]))); // R3
endmodule

// File: tb/llsc_monitor_tb.sv
`timescale 1ns/1ps
module llsc_monitor_tb_top;
    localparam int NREQ  = 2;
    localparam int W     = 32;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    localparam logic [2:0] I = 3'd0, LD = 3'd1, ST = 3'd2, LL = 3'd3, SC = 3'd4;

    typedef struct packed {
        logic [2:0]    op0;
        logic [AW-1:0] a0;
        logic [W-1:0]  d0;
        logic [2:0]    op1;
        logic [AW-1:0] a1;
        logic [W-1:0]  d1;
        logic [W-1:0]  e0;
        logic          w0;
        logic [W-1:0]  e1;
        logic          w1;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [0:NV-1] = '{
        '{ST, 4'd3, 32'h11, I,  4'd0, 32'h0,  32'h0,  1'b1, 32'h0,  1'b0, 8'd10}, // R10
        '{LL, 4'd3, 32'h0,  LD, 4'd3, 32'h0,  32'h11, 1'b0, 32'h11, 1'b0, 8'd2},  // R2
        '{SC, 4'd3, 32'h22, I,  4'd0, 32'h0,  32'h1,  1'b1, 32'h0,  1'b0, 8'd3},  // R3
        '{SC, 4'd3, 32'h33, LD, 4'd3, 32'h0,  32'h0,  1'b0, 32'h22, 1'b0, 8'd5},  // R5
        '{LL, 4'd5, 32'h0,  LL, 4'd5, 32'h0,  32'h0,  1'b0, 32'h0,  1'b0, 8'd2},
        '{ST, 4'd5, 32'h44, SC, 4'd5, 32'h55, 32'h0,  1'b1, 32'h0,  1'b0, 8'd8},  // R8
        '{LD, 4'd5, 32'h0,  I,  4'd0, 32'h0,  32'h44, 1'b0, 32'h0,  1'b0, 8'd8},
        '{LL, 4'd7, 32'h0,  LL, 4'd7, 32'h0,  32'h0,  1'b0, 32'h0,  1'b0, 8'd3},
        '{SC, 4'd7, 32'h66, SC, 4'd7, 32'h77, 32'h1,  1'b1, 32'h0,  1'b0, 8'd7},  // R7
        '{LL, 4'd8, 32'h0,  SC, 4'd8, 32'h99, 32'h0,  1'b0, 32'h0,  1'b0, 8'd4},  // R4
        '{ST, 4'd9, 32'h1,  I,  4'd0, 32'h0,  32'h0,  1'b1, 32'h0,  1'b0, 8'd6},
        '{SC, 4'd8, 32'hAA, LD, 4'd8, 32'h0,  32'h1,  1'b1, 32'hAA, 1'b0, 8'd7},  // R7 R6 R8
        '{I,  4'd0, 32'h0,  LL, 4'd2, 32'h0,  32'h0,  1'b0, 32'h0,  1'b0, 8'd2},
        '{SC, 4'd2, 32'h5,  I,  4'd0, 32'h0,  32'h0,  1'b0, 32'h0,  1'b0, 8'd4},  // R4
        '{I,  4'd0, 32'h0,  SC, 4'd3, 32'h7,  32'h0,  1'b0, 32'h0,  1'b0, 8'd4},  // R4 address differs
        '{ST, 4'd4, 32'hB,  ST, 4'd4, 32'hC,  32'h0,  1'b1, 32'h0,  1'b1, 8'd9},  // R9
        '{LD, 4'd4, 32'h0,  LL, 4'd4, 32'h0,  32'hC,  1'b0, 32'hC,  1'b0, 8'd9},
        '{ST, 4'd4, 32'hD,  I,  4'd0, 32'h0,  32'h0,  1'b1, 32'h0,  1'b0, 8'd6},
        '{LD, 4'd2, 32'h0,  SC, 4'd4, 32'hE,  32'h0,  1'b0, 32'h0,  1'b0, 8'd6},  // R6
        '{LL, 4'd6, 32'h0,  I,  4'd0, 32'h0,  32'h0,  1'b0, 32'h0,  1'b0, 8'd2},
        '{I,  4'd0, 32'h0,  ST, 4'd6, 32'h1,  32'h0,  1'b0, 32'h0,  1'b1, 8'd6},
        '{SC, 4'd6, 32'hF,  I,  4'd0, 32'h0,  32'h0,  1'b0, 32'h0,  1'b0, 8'd6}   // R6
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NREQ-1:0][2:0]    req_op = '0;
    logic [NREQ-1:0][AW-1:0] req_addr = '0;
    logic [NREQ-1:0][W-1:0]  req_wdata = '0;
    logic [NREQ-1:0]         rsp_valid;
    logic [NREQ-1:0][W-1:0]  rsp_data;
    logic [NREQ-1:0]         mem_we;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    llsc_monitor #(.NREQ(NREQ), .W(W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_we(mem_we)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] o0, input logic [AW-1:0] a0, input logic [W-1:0] d0,
                         input logic [2:0] o1, input logic [AW-1:0] a1, input logic [W-1:0] d1);
        @(negedge clk);
        req_op[0] = o0; req_addr[0] = a0; req_wdata[0] = d0;
        req_op[1] = o1; req_addr[1] = a1; req_wdata[1] = d1;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 rsp_valid after reset", {30'b0, rsp_valid}, '0);
        check("R1 mem_we after reset", {30'b0, mem_we}, '0);
        check("R1 rsp_data after reset", rsp_data[0] | rsp_data[1], '0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            vec_t v;
            string t;
            v = VECS[k];
            issue(v.op0, v.a0, v.d0, v.op1, v.a1, v.d1);
            t = $sformatf("R%0d vec%0d", v.req, k);
            check({t, " lane0 data"}, rsp_data[0], v.e0);
            check({t, " lane0 we"}, {31'b0, mem_we[0]}, {31'b0, v.w0});
            check({t, " lane0 valid"}, {31'b0, rsp_valid[0]}, {31'b0, v.op0 != I});
            check({t, " lane1 data"}, rsp_data[1], v.e1);
            check({t, " lane1 we"}, {31'b0, mem_we[1]}, {31'b0, v.w1});
            check({t, " lane1 valid"}, {31'b0, rsp_valid[1]}, {31'b0, v.op1 != I});
        end

        // R1: reset drops a live reservation and clears the store
        issue(LL, 4'd1, 32'h0, ST, 4'd1, 32'h5A);
        issue(LL, 4'd1, 32'h0, I, 4'd0, 32'h0);
        check("R1 pre-reset read", rsp_data[0], 32'h5A);
        @(negedge clk);
        req_op = '0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 outputs in reset", {30'b0, rsp_valid}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        issue(SC, 4'd1, 32'h77, I, 4'd0, 32'h0);
        check("R1 cond store after reset", rsp_data[0], 32'h0);
        check("R1 cond store no write", {31'b0, mem_we[0]}, 32'h0);
        issue(LD, 4'd1, 32'h0, LD, 4'd3, 32'h0);
        check("R1 word cleared lane0", rsp_data[0], 32'h0);
        check("R1 word cleared lane1", rsp_data[1], 32'h0);

        @(negedge clk);
        req_op = '0;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule